// File: doc/BRIEF.md
# Dual-Reference Clock Failover Monitor

This block watches two reference clocks and decides which one a downstream clock stage should lock to. It runs on a free-running monitor clock. Each reference is brought into the monitor domain through its own synchronizer, and a level change at the synchronizer output counts as one edge. A shared timer cuts monitor time into fixed windows. A reference that shows no edge in a whole window is flagged bad. A flagged reference is trusted again only after a parameterized number of back-to-back windows that each contain an edge.

Selection starts on reference 0 after reset. The block moves to the other reference on its own when the selected one is flagged and the other is not. A rising edge on the switch request input flips the selection at once, whatever the flags say, and this takes priority over automatic failover in that cycle. The references must toggle slower than half the monitor clock rate. Deassertion of `rst_n` is expected to be synchronous to `mon_clk`.

Top module: `refclk_failover`

## Requirements
- R1: After reset, `ref_sel` is 0 and both bits of `ref_bad` are 0.
- R2: `ref_bad[0]` goes to 1 when `ref_clk0` stops toggling, at the latest by the end of the second full window after the stop.
- R3: `ref_bad[1]` goes to 1 when `ref_clk1` stops toggling, under the same bound as R2.
- R4: A set bad bit returns to 0 after GOOD_RUNS consecutive windows that each contain an edge of its reference. Bad bits change only on the monitor edge that closes a window.
- R5: `ref_sel` is 0 while reference 0 is in use and 1 while reference 1 is in use.
- R6: When the selected reference's bad bit is 1 and the other reference's bit is 0, `ref_sel` flips on the next monitor edge.
- R7: When both bad bits are 1, automatic failover does not change `ref_sel`.
- R8: A rising edge of `swap_req` (1 now, 0 on the previous edge) flips `ref_sel` on that monitor edge, whatever the flags say. This takes precedence over R6 in the same cycle.
- R9: Holding `swap_req` at 1 for many cycles causes exactly one flip.
- R10: Apart from R6 and R8, `ref_sel` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mon_clk | input | 1 | Free-running monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk0 | input | 1 | Reference clock 0, the default primary |
| ref_clk1 | input | 1 | Reference clock 1 |
| swap_req | input | 1 | Manual switch request, acted on at its rising edge |
| ref_bad | output | 2 | Per-reference loss-of-toggle flags, bit i for reference i |
| ref_sel | output | 1 | Selected reference: 0 or 1 |

## Verification
A manual flip is due on the first monitor edge after `swap_req` rises. The bench drives requests on falling edges and samples one time unit after the next rising edge. Any failover caused by that flip lands one edge later, so it is checked two edges after the request. Flag changes depend on the synchronizer latency and on where the stop falls within a window. The bench therefore waits a settle time of (GOOD_RUNS+4) windows, which is longer than the worst case for both setting and clearing, before it compares the flags and the settled selection against its model. Both references come from one phase counter, so references that are running always make their flag decisions on the same edge.

// File: rtl/refsw_pkg.sv
package refsw_pkg;
  typedef enum logic {
    SEL_REF0 = 1'b0,
    SEL_REF1 = 1'b1
  } refsel_e;

  localparam int unsigned NUM_REFS = 2;
endpackage

// File: rtl/refsw_edge_sense.sv
module refsw_edge_sense #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic tog
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // a level change past the synchronizer counts as one edge
  assign tog = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/refsw_window_timer.sv
module refsw_window_timer #(
  parameter int unsigned WIN_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  output logic win_end
);
  localparam int unsigned CW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign win_end = (cnt_q == LAST);

  always_comb begin
    if (win_end) cnt_d = '0;
    else         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/refsw_activity_judge.sv
module refsw_activity_judge #(
  parameter int unsigned GOOD_RUNS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tog,
  input  logic win_end,
  output logic bad
);
  localparam int unsigned RW = (GOOD_RUNS > 1) ? $clog2(GOOD_RUNS) : 1;
  localparam logic [RW-1:0] RUN_LAST = RW'(GOOD_RUNS - 1);

  logic          seen_q, seen_d;
  logic          bad_q, bad_d;
  logic [RW-1:0] run_q, run_d;
  logic          hit;

  assign hit = seen_q | tog;

  always_comb begin
    seen_d = seen_q;
    bad_d  = bad_q;
    run_d  = run_q;
    if (win_end) begin
      seen_d = 1'b0;
      if (!hit) begin
        bad_d = 1'b1;
        run_d = '0;
      end else if (bad_q) begin
        if (run_q == RUN_LAST) begin
          bad_d = 1'b0;
          run_d = '0;
        end else begin
          run_d = run_q + 1'b1;
        end
      end
    end else if (tog) begin
      seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      bad_q  <= 1'b0;
      run_q  <= '0;
    end else begin
      seen_q <= seen_d;
      bad_q  <= bad_d;
      run_q  <= run_d;
    end
  end

  assign bad = bad_q;
endmodule

// File: rtl/refsw_selector.sv
module refsw_selector
  import refsw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       swap_req,
  input  logic [1:0] bad,
  output logic       sel
);
  refsel_e sel_q, sel_d;
  logic    req_q;
  logic    man_rise;
  logic    cur_bad, alt_bad;

  assign man_rise = swap_req & ~req_q;
  assign cur_bad  = bad[sel_q];
  assign alt_bad  = bad[~sel_q];

  always_comb begin
    sel_d = sel_q;
    if (man_rise)                sel_d = refsel_e'(~sel_q);
    else if (cur_bad && !alt_bad) sel_d = refsel_e'(~sel_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SEL_REF0;
      req_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      req_q <= swap_req;
    end
  end

  assign sel = sel_q;
endmodule

// File: rtl/refclk_failover.sv
module refclk_failover
  import refsw_pkg::*;
#(
  parameter int unsigned WIN_CYC     = 32,
  parameter int unsigned GOOD_RUNS   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       mon_clk,
  input  logic       rst_n,
  input  logic       ref_clk0,
  input  logic       ref_clk1,
  input  logic       swap_req,
  output logic [1:0] ref_bad,
  output logic       ref_sel
);
  logic [NUM_REFS-1:0] ref_in;
  logic [NUM_REFS-1:0] ref_tog;
  logic                win_end;

  assign ref_in = {ref_clk1, ref_clk0};

  refsw_window_timer #(.WIN_CYC(WIN_CYC)) i_timer (
    .clk     (mon_clk),
    .rst_n   (rst_n),
    .win_end (win_end)
  );

  for (genvar i = 0; i < NUM_REFS; i++) begin : g_ref
    refsw_edge_sense #(.STAGES(SYNC_STAGES)) i_sense (
      .clk      (mon_clk),
      .rst_n    (rst_n),
      .async_in (ref_in[i]),
      .tog      (ref_tog[i])
    );
    refsw_activity_judge #(.GOOD_RUNS(GOOD_RUNS)) i_judge (
      .clk     (mon_clk),
      .rst_n   (rst_n),
      .tog     (ref_tog[i]),
      .win_end (win_end),
      .bad     (ref_bad[i])
    );
  end

  refsw_selector i_sel (
    .clk      (mon_clk),
    .rst_n    (rst_n),
    .swap_req (swap_req),
    .bad      (ref_bad),
    .sel      (ref_sel)
  );
endmodule

module refsw_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       swap_req,
  input logic [1:0] ref_bad,
  input logic       ref_sel,
  input logic       win_end
);
  logic req_q;
  logic man;
  logic fail_over;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= swap_req;
  end

  assign man       = swap_req && !req_q;
  assign fail_over = ref_bad[ref_sel] && !ref_bad[!ref_sel];

  // R8
  manual_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    man |=> (ref_sel != $past(ref_sel)));

  // R6
  auto_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!man && fail_over) |=> (ref_sel != $past(ref_sel)));

  // R10
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!man && !fail_over) |=> $stable(ref_sel));

  // R7
  both_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!man && (ref_bad == 2'b11)) |=> $stable(ref_sel));

  // R4
  flag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(ref_bad));
endmodule

bind refclk_failover refsw_checker i_chk (
  .clk      (mon_clk),
  .rst_n    (rst_n),
  .swap_req (swap_req),
  .ref_bad  (ref_bad),
  .ref_sel  (ref_sel),
  .win_end  (win_end)
);

// File: tb/test_refclk_failover.sv
`timescale 1ns/1ps
module test_refclk_failover;
  localparam int unsigned WIN    = 32;
  localparam int unsigned GOOD   = 4;
  localparam int unsigned SETTLE = (GOOD + 4) * WIN;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run0 = 1'b1;
  logic       run1 = 1'b1;
  logic       swap_req = 1'b0;
  logic [1:0] ph = 2'b00;
  logic [1:0] ref_bad;
  logic       ref_sel;
  logic       exp_sel;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #5ns clk = ~clk;
  always @(negedge clk) ph <= ph + 2'd1;

  refclk_failover #(.WIN_CYC(WIN), .GOOD_RUNS(GOOD), .SYNC_STAGES(2)) i_refclk_failover (
    .mon_clk  (clk),
    .rst_n    (rst_n),
    .ref_clk0 (run0 & ph[1]),
    .ref_clk1 (run1 & ph[1]),
    .swap_req (swap_req),
    .ref_bad  (ref_bad),
    .ref_sel  (ref_sel)
  );

  function automatic logic failover(logic s, logic [1:0] b);
    if (b[s] && !b[!s]) return !s;
    return s;
  endfunction

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1ns;
  endtask

  task automatic set_runs(logic a, logic b);
    @(negedge clk);
    run0 = a;
    run1 = b;
    step(SETTLE);
    chk("R2/R3/R4 flags", ref_bad, {~b, ~a});
    exp_sel = failover(exp_sel, {~b, ~a});
    chk("R6/R7 settled sel", {1'b0, ref_sel}, {1'b0, exp_sel});
  endtask

  task automatic pulse_swap();
    @(negedge clk);
    swap_req = 1'b1;
    step(1);
    exp_sel = !exp_sel;
    chk("R8 manual flip", {1'b0, ref_sel}, {1'b0, exp_sel});
    @(negedge clk);
    swap_req = 1'b0;
    step(2);
    exp_sel = failover(exp_sel, ref_bad);
    chk("R6 after manual", {1'b0, ref_sel}, {1'b0, exp_sel});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    exp_sel = 1'b0;
    step(3);
    chk("R1 reset flags", ref_bad, 2'b00);
    chk("R1 reset sel", {1'b0, ref_sel}, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    step(SETTLE);
    chk("R1 flags stay clear", ref_bad, 2'b00);
    chk("R5 sel on ref0", {1'b0, ref_sel}, 2'b00);

    // R9: held request gives exactly one flip
    @(negedge clk);
    swap_req = 1'b1;
    step(1);
    chk("R9 first flip", {1'b0, ref_sel}, 2'b01);
    step(10);
    chk("R9 held level no more flips", {1'b0, ref_sel}, 2'b01);
    @(negedge clk);
    swap_req = 1'b0;
    step(3);
    chk("R10 release no flip", {1'b0, ref_sel}, 2'b01);
    exp_sel = 1'b1;

    // R3, R6: lose ref1 while it is selected
    set_runs(1'b1, 1'b0);
    chk("R5 sel back on ref0", {1'b0, ref_sel}, 2'b00);
    // R8 precedence: manual onto bad ref1, auto returns
    pulse_swap();
    // R4: ref1 recovers
    set_runs(1'b1, 1'b1);
    // R2, R6: lose ref0
    set_runs(1'b0, 1'b1);
    chk("R5 sel on ref1", {1'b0, ref_sel}, 2'b01);
    // R7: both lost, no automatic move
    set_runs(1'b0, 1'b0);
    pulse_swap();
    set_runs(1'b1, 1'b1);

    for (int it = 0; it < 30; it++) begin
      set_runs(($urandom % 4) != 0, ($urandom % 4) != 0);
      if ($urandom % 2) pulse_swap();
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule